// File: doc/BRIEF.md
# Page Program Merge Buffer

This block sits behind the serial front end of a page-organised flash model and turns the data phase of a page-program command into a write of one page. A start strobe gives the target address. Its upper bits select the page, and its low bits give the first in-page offset. Each byte strobe that follows stores a byte in a page-sized staging buffer at the current offset. The offset then advances and wraps inside the page, so the block never crosses into the next page. A per-offset dirty mask records which offsets received data.

The front end closes the command with an end strobe and a flag that tells whether the end fell exactly on a byte boundary. An aligned end starts a commit walk over every offset of the page. The walk ANDs each dirty buffer entry into the stored byte, because programming can only turn ones into zeros, and it skips the clean entries. A misaligned end or an explicit abort throws the staged data away and leaves the array untouched. The array itself is a small reset-to-erased memory model with one read port for observation.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset, busy_o and done_o are 0 and every array byte reads 0xFF.
- R2: A committed byte is stored as the old array byte ANDed with the received byte, so no bit can go from 0 to 1.
- R3: Offsets are the low log2(PAGE_BYTES) address bits. After offset PAGE_BYTES-1 the next byte lands at offset 0 of the same page, and the other pages stay unchanged.
- R4: When more than PAGE_BYTES bytes arrive, a later byte replaces the earlier byte at the same offset. Only the last PAGE_BYTES bytes reach the array.
- R5: Offsets of the target page that received no byte keep their previous content after a commit.
- R6: cmd_end_i with end_aligned_i=1 starts a commit. cmd_end_i with end_aligned_i=0 discards the staged bytes, writes nothing and does not raise busy_o.
- R7: abort_i discards the staged bytes without touching the array. A later aligned end with no new bytes writes nothing. abort_i wins over a simultaneous aligned end.
- R8: busy_o is high for exactly PAGE_BYTES consecutive cycles after an accepted commit. done_o is high for one cycle, in the first cycle with busy_o low.
- R9: While busy_o is high, start_i, byte_vld_i, cmd_end_i and abort_i are ignored. Bytes offered during a walk never reach the array, even through a later commit.
- R10: A byte strobe in the same cycle as an aligned end is stored and is part of that commit.
- R11: start_i clears the dirty mask and loads the page and offset. A byte strobe in the same cycle as start_i is dropped, so the next byte lands at the start offset.
- R12: A byte strobe in the same cycle as abort_i is dropped together with the rest of the staged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin collecting a new command |
| start_addr_i | input | ADDR_W | Target address: page in the upper bits, offset in the low bits |
| byte_vld_i | input | 1 | One received data byte is present |
| byte_i | input | DATA_W | Received data byte |
| cmd_end_i | input | 1 | Command ended (chip deselect seen) |
| end_aligned_i | input | 1 | End fell exactly on a byte boundary |
| abort_i | input | 1 | Drop staged data |
| rd_addr_i | input | ADDR_W | Array observation address |
| rd_data_o | output | DATA_W | Array byte at rd_addr_i |
| busy_o | output | 1 | Commit walk in progress |
| done_o | output | 1 | One-cycle pulse when the walk finishes |

## Verification
Byte capture and command closing can arrive in the same cycle. The bench provokes this by raising a byte strobe together with an aligned end, and separately together with abort_i and together with start_i. It judges each case by sweeping the whole array after the walk. The last strobe must appear ANDed into its offset in the aligned case. It must leave no trace in the abort case. In the start case it must be replaced by the following byte at the start offset. The bench also fires start, byte and end strobes all at once while a walk is running, and confirms that only the earlier command reaches the array.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;

endpackage

// File: rtl/pgbuf_collect.sv
module pgbuf_collect #(
  parameter int PAGE_BYTES = 256,
  parameter int PAGE_W     = 2,
  parameter int DATA_W     = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          busy_i,
  input  logic                          start_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] start_ofs_i,
  input  logic [PAGE_W-1:0]             start_page_i,
  input  logic                          byte_vld_i,
  input  logic [DATA_W-1:0]             byte_i,
  input  logic                          discard_i,
  input  logic                          clear_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx_i,
  output logic                          rd_dirty_o,
  output logic [DATA_W-1:0]             rd_byte_o,
  output logic [PAGE_W-1:0]             page_o
);

  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PAGE_BYTES - 1);

  logic [OFS_W-1:0]  ptr_q, ptr_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [PAGE_BYTES-1:0] dirty_q;
  logic [DATA_W-1:0] stage_q [PAGE_BYTES];

  logic accept;
  logic take_start;
  logic take_byte;
  logic clear_all;

  always_comb begin
    accept     = !busy_i;
    take_start = accept && start_i;
    take_byte  = accept && byte_vld_i && !start_i && !discard_i;
    clear_all  = clear_i || (accept && (start_i || discard_i));
  end

  always_comb begin
    ptr_d  = ptr_q;
    page_d = page_q;
    if (take_start) begin
      ptr_d  = start_ofs_i;
      page_d = start_page_i;
    end else if (take_byte) begin
      if (ptr_q == LAST_OFS) ptr_d = '0;
      else                   ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      page_q <= '0;
    end else if (take_start || take_byte) begin
      ptr_q  <= ptr_d;
      page_q <= page_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_q <= '0;
    end else if (clear_all) begin
      dirty_q <= '0;
    end else if (take_byte) begin
      dirty_q[ptr_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (take_byte) begin
      stage_q[ptr_q] <= byte_i;
    end
  end

  always_comb begin
    rd_dirty_o = dirty_q[rd_idx_i];
    rd_byte_o  = stage_q[rd_idx_i];
    page_o     = page_q;
  end

endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit
  import pgbuf_pkg::*;
#(
  parameter int PAGE_BYTES = 256
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          go_i,
  input  logic                          dirty_i,
  output logic [$clog2(PAGE_BYTES)-1:0] idx_o,
  output logic                          wr_en_o,
  output logic                          clear_o,
  output logic                          busy_o,
  output logic                          done_o
);

  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PAGE_BYTES - 1);

  walk_state_e      state_q, state_d;
  logic [OFS_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             last;

  always_comb begin
    last    = (state_q == WALK_RUN) && (idx_q == LAST_OFS);
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    unique case (state_q)
      WALK_IDLE: begin
        if (go_i) begin
          state_d = WALK_RUN;
          idx_d   = '0;
        end
      end
      WALK_RUN: begin
        if (last) begin
          state_d = WALK_IDLE;
          idx_d   = '0;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WALK_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    idx_o   = idx_q;
    busy_o  = (state_q == WALK_RUN);
    wr_en_o = (state_q == WALK_RUN) && dirty_i;
    clear_o = last;
    done_o  = done_q;
  end

endmodule

// File: rtl/pgbuf_array.sv
module pgbuf_array #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_mask_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] cell_q [DEPTH];

  // Programming can only clear bits: the new value is old AND incoming.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) begin
        cell_q[w] <= '1;
      end
    end else if (wr_en_i) begin
      cell_q[wr_addr_i] <= cell_q[wr_addr_i] & wr_mask_i;
    end
  end

  always_comb begin
    rd_data_o = cell_q[rd_addr_i];
  end

endmodule

// File: rtl/page_prog_buffer.sv
module page_prog_buffer #(
  parameter int PAGE_BYTES = 256,
  parameter int NUM_PAGES  = 4,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = $clog2(PAGE_BYTES) + $clog2(NUM_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              cmd_end_i,
  input  logic              end_aligned_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int DEPTH  = NUM_PAGES * PAGE_BYTES;

  logic              discard;
  logic              go;
  logic              busy;
  logic              clear;
  logic              wr_en;
  logic              cur_dirty;
  logic [OFS_W-1:0]  walk_idx;
  logic [DATA_W-1:0] cur_byte;
  logic [PAGE_W-1:0] page;

  always_comb begin
    discard = abort_i || (cmd_end_i && !end_aligned_i);
    go      = cmd_end_i && end_aligned_i && !abort_i;
  end

  pgbuf_collect #(
    .PAGE_BYTES (PAGE_BYTES),
    .PAGE_W     (PAGE_W),
    .DATA_W     (DATA_W)
  ) u_collect (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy),
    .start_i      (start_i),
    .start_ofs_i  (start_addr_i[OFS_W-1:0]),
    .start_page_i (start_addr_i[ADDR_W-1:OFS_W]),
    .byte_vld_i   (byte_vld_i),
    .byte_i       (byte_i),
    .discard_i    (discard),
    .clear_i      (clear),
    .rd_idx_i     (walk_idx),
    .rd_dirty_o   (cur_dirty),
    .rd_byte_o    (cur_byte),
    .page_o       (page)
  );

  pgbuf_commit #(
    .PAGE_BYTES (PAGE_BYTES)
  ) u_commit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .dirty_i (cur_dirty),
    .idx_o   (walk_idx),
    .wr_en_o (wr_en),
    .clear_o (clear),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  pgbuf_array #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i ({page, walk_idx}),
    .wr_mask_i (cur_byte),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  assign busy_o = busy;

endmodule

// File: rtl/page_prog_buffer_chk.sv
module page_prog_buffer_chk #(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_end_i,
  input logic              end_aligned_i,
  input logic              abort_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              busy_o,
  input logic              done_o
);

  localparam int CNT_W = $clog2(PAGE_BYTES) + 2;

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (busy_o)  run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_DONE_AFTER_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R8

  AST_WALK_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == CNT_W'(PAGE_BYTES))); // R8

  AST_ALIGNED_END_WALKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_end_i && end_aligned_i && !abort_i) |=> busy_o); // R6

  AST_DISCARD_NO_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (abort_i || (cmd_end_i && !end_aligned_i))) |=> !busy_o); // R7

  AST_ARRAY_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && $stable(rd_addr_i)) |-> $stable(rd_data_o)); // R9

endmodule

bind page_prog_buffer page_prog_buffer_chk #(
  .PAGE_BYTES (PAGE_BYTES),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_end_i     (cmd_end_i),
  .end_aligned_i (end_aligned_i),
  .abort_i       (abort_i),
  .rd_addr_i     (rd_addr_i),
  .rd_data_o     (rd_data_o),
  .busy_o        (busy_o),
  .done_o        (done_o)
);

// File: tb/sim_page_prog_buffer.sv
module sim_page_prog_buffer;

  localparam int PB     = 256;
  localparam int NP     = 4;
  localparam int AW     = 10;
  localparam int DEPTH  = PB * NP;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          start_i, byte_vld_i, cmd_end_i, end_aligned_i, abort_i;
  logic [AW-1:0] start_addr_i, rd_addr_i;
  logic [7:0]    byte_i, rd_data_o;
  logic          busy_o, done_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] exp_mem [DEPTH];
  logic [7:0] pend    [PB];
  logic       pvld    [PB];
  int         cur_ofs;
  int         cur_page;

  always #4 clk_i = ~clk_i;

  page_prog_buffer #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .DATA_W(8), .ADDR_W(AW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    start_i = 0; byte_vld_i = 0; cmd_end_i = 0; end_aligned_i = 0; abort_i = 0;
    byte_i = 8'h00; start_addr_i = '0;
  endtask

  task automatic model_clear();
    for (int o = 0; o < PB; o++) pvld[o] = 1'b0;
  endtask

  task automatic model_byte(input logic [7:0] b);
    pend[cur_ofs] = b;
    pvld[cur_ofs] = 1'b1;
    cur_ofs = (cur_ofs + 1) % PB;
  endtask

  task automatic model_commit();
    for (int o = 0; o < PB; o++)
      if (pvld[o]) exp_mem[cur_page*PB + o] = exp_mem[cur_page*PB + o] & pend[o];
    model_clear();
  endtask

  task automatic step();
    @(posedge clk_i); #1; idle_inputs();
  endtask

  task automatic do_start(input int addr);
    @(negedge clk_i); start_i = 1; start_addr_i = AW'(addr); step();
    cur_page = addr / PB; cur_ofs = addr % PB; model_clear();
  endtask

  task automatic do_byte(input logic [7:0] b);
    @(negedge clk_i); byte_vld_i = 1; byte_i = b; step();
    model_byte(b);
  endtask

  task automatic do_end(input logic aligned);
    @(negedge clk_i); cmd_end_i = 1; end_aligned_i = aligned; step();
    if (aligned) model_commit(); else model_clear();
  endtask

  task automatic wait_walk(input string req, input int pre);
    int n = pre;
    @(negedge clk_i);
    while (busy_o && n < 1000) begin n++; @(negedge clk_i); end
    chk(req, n, PB, "busy cycles");
    chk("R8", done_o, 1, "done after walk");
    @(negedge clk_i);
    chk("R8", done_o, 0, "done one cycle");
  endtask

  task automatic sweep(input string req, input string what);
    int bad = 0; int first_a = -1; int fa = 0; int fe = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr_i = AW'(a); #0.5;
      if (rd_data_o !== exp_mem[a]) begin
        bad++;
        if (first_a < 0) begin first_a = a; fa = rd_data_o; fe = exp_mem[a]; end
      end
    end
    n_chk++;
    if (bad != 0) begin
      n_bad++;
      $display("FAIL %s %s: %0d bytes differ, at %0h actual %0h expected %0h",
               req, what, bad, first_a, fa, fe);
    end
  endtask

  initial begin
    #1500000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle_inputs(); rd_addr_i = '0; rst_ni = 0;
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    model_clear(); cur_ofs = 0; cur_page = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    chk("R1", busy_o, 0, "busy at reset");
    chk("R1", done_o, 0, "done at reset");
    sweep("R1", "erased after reset");

    // R2 R5: few bytes at page 1 offset 0, then AND over them
    do_start(1*PB + 0);
    do_byte(8'hA5); do_byte(8'h3C); do_byte(8'h0F); do_byte(8'hF0);
    do_end(1'b1); wait_walk("R8", 0);
    sweep("R5", "partial page program");
    do_start(1*PB + 1);
    do_byte(8'h5A); do_byte(8'hFF); do_byte(8'h81);
    do_end(1'b1); wait_walk("R8", 0);
    sweep("R2", "AND merge over programmed bytes");

    // R3: wrap inside page 2
    do_start(2*PB + 250);
    for (int i = 0; i < 10; i++) do_byte(8'((i * 29) ^ 8'h6B));
    do_end(1'b1); wait_walk("R8", 0);
    sweep("R3", "offset wrap within page");

    // R4: 300 bytes into page 3, only the last 256 survive
    do_start(3*PB + 16);
    for (int i = 0; i < 300; i++) do_byte(8'(i * 37 + 11));
    do_end(1'b1); wait_walk("R8", 0);
    sweep("R4", "overflow keeps last bytes");

    // R6: misaligned end writes nothing
    do_start(0);
    do_byte(8'h00); do_byte(8'h00);
    do_end(1'b0);
    @(negedge clk_i);
    chk("R6", busy_o, 0, "no walk on misaligned end");
    sweep("R6", "misaligned end discards");

    // R7: abort then aligned end with nothing staged
    do_start(0 + 7);
    do_byte(8'h00); do_byte(8'h11);
    @(negedge clk_i); abort_i = 1; step(); model_clear();
    @(negedge clk_i);
    chk("R7", busy_o, 0, "no walk on abort");
    do_end(1'b1); wait_walk("R7", 0);
    sweep("R7", "abort leaves array");
    // abort wins over aligned end
    do_start(0 + 9); do_byte(8'h00);
    @(negedge clk_i); abort_i = 1; cmd_end_i = 1; end_aligned_i = 1; step(); model_clear();
    @(negedge clk_i);
    chk("R7", busy_o, 0, "abort beats aligned end");
    sweep("R7", "abort with end leaves array");

    // R9: strobes during a walk are ignored
    do_start(1*PB + 100);
    do_byte(8'hC3); do_byte(8'h96);
    do_end(1'b1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      start_i = 1; start_addr_i = AW'(k); byte_vld_i = 1; byte_i = 8'h00;
      cmd_end_i = 1; end_aligned_i = 1; abort_i = (k == 4);
      step();
    end
    wait_walk("R9", 5);
    sweep("R9", "only the earlier command lands");
    do_end(1'b1); wait_walk("R9", 0);
    sweep("R9", "bytes offered while busy never land");

    // R10: last byte in the same cycle as the aligned end
    do_start(2*PB + 60);
    do_byte(8'hE7);
    @(negedge clk_i); byte_vld_i = 1; byte_i = 8'h18; cmd_end_i = 1; end_aligned_i = 1; step();
    model_byte(8'h18); model_commit();
    wait_walk("R8", 0);
    sweep("R10", "byte with end is committed");

    // R11: start and byte in the same cycle, byte dropped
    @(negedge clk_i); start_i = 1; start_addr_i = AW'(0*PB + 5); byte_vld_i = 1; byte_i = 8'h00; step();
    cur_page = 0; cur_ofs = 5; model_clear();
    do_byte(8'h12);
    do_end(1'b1); wait_walk("R8", 0);
    sweep("R11", "byte with start dropped");
    chk("R11", exp_mem[5], 8'h12, "start offset target");

    // R12: byte in the same cycle as abort
    do_start(0*PB + 40);
    do_byte(8'h55);
    @(negedge clk_i); abort_i = 1; byte_vld_i = 1; byte_i = 8'h00; step(); model_clear();
    do_end(1'b1); wait_walk("R8", 0);
    sweep("R12", "byte with abort dropped");

    // full page in one command, R2 over prior content of page 1
    do_start(1*PB + 0);
    for (int i = 0; i < PB; i++) do_byte(8'(~i));
    do_end(1'b1); wait_walk("R8", 0);
    sweep("R2", "full page AND merge");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule